// File: doc/BRIEF.md
# Mixed-Page-Size Translation Lookaside Buffer with Entry Locking

This block caches virtual-to-physical translations of three granularities in one fully associative store: 4KB small pages, 64KB large pages and 1MB sections. A lookup presents a 32-bit virtual address with a request strobe and receives, in the same cycle, a hit or miss indication, the translated physical address and the 2-bit access-permission code that applies. Large pages carry four permission codes, one for each 16KB quarter of the page. Which one applies depends on the address being translated.

Translations are installed one at a time through a refill port, normally driven by an external page-table walker that reacts to the miss output. A round-robin replacement pointer chooses where each refill lands. Entries refilled with the lock flag set are never chosen as victims, so that latency-critical mappings such as interrupt handlers stay resident. Maintenance inputs flush all unlocked translations (for a context switch), flush only the entries covering one address, or release every lock.

Top module: `mpt_tlb`

## Requirements
- R1: After reset no entry is valid or locked, the replacement pointer is at entry 0, every lookup misses and `rf_err` is low.
- R2: A small-page entry (size code 2'b01) matches when VA[31:12] equals its tag. The physical address is {base[31:12], VA[11:0]} and the permission is `rf_ap[1:0]` as given at refill.
- R3: A large-page entry (size code 2'b10) matches on VA[31:16]. The physical address is {base[31:16], VA[15:0]} and the permission is the 2-bit field `rf_ap[2*VA[15:14] +: 2]` as given at refill.
- R4: A section entry (size code 2'b11) matches on VA[31:20]. The physical address is {base[31:20], VA[19:0]} and the permission is `rf_ap[1:0]`.
- R5: Lookup is combinational. `lk_hit` equals `lk_req` AND any match, and `lk_miss` equals `lk_req` AND no match. `lk_pa` and `lk_ap` are zero unless `lk_hit` is high. When several entries match, the lowest-numbered entry supplies the result.
- R6: A refill with size code 2'b00 writes nothing and leaves the pointer unchanged.
- R7: A refill lands in the first unlocked entry at or after the pointer, counting circularly, and the pointer then moves to the entry after it. After reset, refills fill entries 0, 1, 2 and so on in order.
- R8: When every entry is locked, a refill is dropped and `rf_err` is high for exactly the one cycle after the refill edge.
- R9: `inv_all` clears every unlocked entry. Locked entries stay valid.
- R10: `inv_va_en` clears every entry that covers `inv_va`, whether it is locked or not. Other entries are untouched.
- R11: `unlock_all` clears every lock bit. A refill in the same cycle keeps its own lock flag.
- R12: When an invalidate and a refill arrive in the same cycle, the refill is discarded. A lookup in that cycle sees the contents as they were before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request strobe |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup found a valid covering entry |
| lk_miss | output | 1 | Lookup requested and nothing covers it |
| lk_pa | output | 32 | Translated physical address (zero unless hit) |
| lk_ap | output | 2 | Applicable permission code (zero unless hit) |
| rf_we | input | 1 | Refill strobe |
| rf_size | input | 2 | Refill size: 00 none, 01 small, 10 large, 11 section |
| rf_va | input | 32 | Virtual address whose upper bits form the tag |
| rf_pa | input | 32 | Physical base; low offset bits ignored |
| rf_ap | input | 8 | Four 2-bit permission codes (only [1:0] used unless large) |
| rf_lock | input | 1 | Lock the refilled entry against replacement |
| rf_err | output | 1 | Previous-cycle refill dropped because all entries are locked |
| inv_all | input | 1 | Invalidate all unlocked entries |
| inv_va_en | input | 1 | Invalidate the entries covering inv_va |
| inv_va | input | 32 | Address for selective invalidate |
| unlock_all | input | 1 | Clear every lock bit |

## Verification
A corrupted tag or size field shows up the next time that region is looked up, as a wrong hit, a wrong miss or a physical address built from the wrong offset width. A wrong lock bit or a wrong pointer stays hidden until replacement wraps around. It then appears as a locked mapping that is evicted, or as an unexpected entry that is lost, on the first refill after the pointer passes the affected slot. So the bench fills the store completely before it checks eviction. Invalidate mistakes are visible on the lookup in the very next cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        PG_NONE  = 2'b00,
        PG_SMALL = 2'b01,
        PG_LARGE = 2'b10,
        PG_SECT  = 2'b11
    } pg_size_e;

    localparam int VA_W  = 32;
    localparam int TAG_W = 20;
    localparam int AP_W  = 2;
    localparam int APS_W = 4 * AP_W;

    typedef struct packed {
        logic             vld;
        logic             lck;
        pg_size_e         size;
        logic [TAG_W-1:0] vtag;
        logic [TAG_W-1:0] pbase;
        logic [APS_W-1:0] ap;
    } tlb_ent_t;

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  logic             vld,
    input  pg_size_e         size,
    input  logic [TAG_W-1:0] vtag,
    input  logic [VA_W-1:0]  va,
    output logic             hit
);
    logic cmp;

    always_comb begin
        unique case (size)
            PG_SMALL: cmp = (vtag == va[31:12]);
            PG_LARGE: cmp = (vtag[19:4] == va[31:16]);
            PG_SECT:  cmp = (vtag[19:8] == va[31:20]);
            default:  cmp = 1'b0;
        endcase
        hit = vld & cmp;
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
(
    input  pg_size_e         size,
    input  logic [TAG_W-1:0] pbase,
    input  logic [APS_W-1:0] ap,
    input  logic [VA_W-1:0]  va,
    output logic [VA_W-1:0]  pa,
    output logic [AP_W-1:0]  perm
);
    always_comb begin
        unique case (size)
            PG_SMALL: begin
                pa   = {pbase, va[11:0]};
                perm = ap[1:0];
            end
            PG_LARGE: begin
                pa   = {pbase[19:4], va[15:0]};
                perm = ap[{va[15:14], 1'b0} +: AP_W];
            end
            PG_SECT: begin
                pa   = {pbase[19:8], va[19:0]};
                perm = ap[1:0];
            end
            default: begin
                pa   = '0;
                perm = '0;
            end
        endcase
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N = 64,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  lock_vec,
    input  logic [IW-1:0] ptr,
    output logic [IW-1:0] vict,
    output logic          ok
);
    always_comb begin
        ok   = 1'b0;
        vict = ptr;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(ptr) + k) % N;
            if (!ok && !lock_vec[j]) begin
                ok   = 1'b1;
                vict = IW'(j);
            end
        end
    end
endmodule

// File: rtl/mpt_tlb.sv
module mpt_tlb
    import tlb_pkg::*;
#(
    parameter int N = 64,
    localparam int IW = $clog2(N)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lk_req,
    input  logic [31:0] lk_va,
    output logic        lk_hit,
    output logic        lk_miss,
    output logic [31:0] lk_pa,
    output logic [1:0]  lk_ap,
    input  logic        rf_we,
    input  logic [1:0]  rf_size,
    input  logic [31:0] rf_va,
    input  logic [31:0] rf_pa,
    input  logic [7:0]  rf_ap,
    input  logic        rf_lock,
    output logic        rf_err,
    input  logic        inv_all,
    input  logic        inv_va_en,
    input  logic [31:0] inv_va,
    input  logic        unlock_all
);
    tlb_ent_t      ent [N];
    logic [N-1:0]  lk_match;
    logic [N-1:0]  inv_match;
    logic [N-1:0]  lock_vec;
    logic [IW-1:0] ptr;
    logic [IW-1:0] vict;
    logic          vict_ok;
    logic [IW-1:0] win;
    logic          any_hit;
    logic          win_lock;
    pg_size_e      win_size;
    logic [31:0]   x_pa;
    logic [1:0]    x_ap;
    logic          rf_valid;
    logic          inv_any;
    logic          commit;

    // per-entry matchers for lookup and for selective invalidate
    for (genvar i = 0; i < N; i++) begin : g_ent
        tlb_match u_lk (
            .vld (ent[i].vld),
            .size(ent[i].size),
            .vtag(ent[i].vtag),
            .va  (lk_va),
            .hit (lk_match[i])
        );
        tlb_match u_inv (
            .vld (ent[i].vld),
            .size(ent[i].size),
            .vtag(ent[i].vtag),
            .va  (inv_va),
            .hit (inv_match[i])
        );
        assign lock_vec[i] = ent[i].lck;
    end

    // lowest-numbered matching entry wins
    always_comb begin
        win = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (lk_match[i]) win = IW'(i);
        end
    end

    assign any_hit  = |lk_match;
    assign inv_any  = |inv_match;
    assign win_lock = ent[win].lck;
    assign win_size = ent[win].size;

    tlb_xlate u_xlate (
        .size (ent[win].size),
        .pbase(ent[win].pbase),
        .ap   (ent[win].ap),
        .va   (lk_va),
        .pa   (x_pa),
        .perm (x_ap)
    );

    assign lk_hit  = lk_req & any_hit;
    assign lk_miss = lk_req & ~any_hit;
    assign lk_pa   = lk_hit ? x_pa : '0;
    assign lk_ap   = lk_hit ? x_ap : '0;

    tlb_victim #(.N(N)) u_victim (
        .lock_vec(lock_vec),
        .ptr     (ptr),
        .vict    (vict),
        .ok      (vict_ok)
    );

    assign rf_valid = rf_we && (pg_size_e'(rf_size) != PG_NONE) && !inv_all && !inv_va_en;
    assign commit   = rf_valid && vict_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ent[i] <= '0;
            ptr    <= '0;
            rf_err <= 1'b0;
        end else begin
            rf_err <= rf_valid && !vict_ok;
            if (inv_all) begin
                for (int i = 0; i < N; i++) begin
                    if (!ent[i].lck) ent[i].vld <= 1'b0;
                end
            end
            if (inv_va_en) begin
                for (int i = 0; i < N; i++) begin
                    if (inv_match[i]) ent[i].vld <= 1'b0;
                end
            end
            if (unlock_all) begin
                for (int i = 0; i < N; i++) ent[i].lck <= 1'b0;
            end
            if (commit) begin
                ent[vict].vld   <= 1'b1;
                ent[vict].lck   <= rf_lock;
                ent[vict].size  <= pg_size_e'(rf_size);
                ent[vict].vtag  <= rf_va[31:12];
                ent[vict].pbase <= rf_pa[31:12];
                ent[vict].ap    <= rf_ap;
                ptr <= (vict == IW'(N - 1)) ? '0 : vict + 1'b1;
            end
        end
    end

    // R5: a hit always comes from a populated size code
    a_r5_hit_sized: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (win_size != PG_NONE));

    // R7: the replacement choice never lands on a locked entry
    a_r7_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !ent[vict].lck);

    // R8: an error follows only a refill made while every entry was locked
    a_r8_err_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rf_err) |-> ($past(rf_we) && $past(&lock_vec)));

    // R9: after a flush, only locked entries can still hit
    a_r9_flush_keeps_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !unlock_all) |=> !(lk_hit && !win_lock));

    // R10: after a selective invalidate nothing covers that address
    a_r10_inv_va_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inv_va_en |=> (!$stable(inv_va) || !inv_any));

    // R11: unlock-all leaves no locks when no refill competes
    a_r11_unlock_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_all && !rf_we) |=> ($countones(lock_vec) == 0));
endmodule

// File: tb/sim_mpt_tlb.sv
module sim_mpt_tlb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_req;
    logic [31:0] lk_va;
    logic        lk_hit, lk_miss;
    logic [31:0] lk_pa;
    logic [1:0]  lk_ap;
    logic        rf_we;
    logic [1:0]  rf_size;
    logic [31:0] rf_va, rf_pa;
    logic [7:0]  rf_ap;
    logic        rf_lock;
    logic        rf_err;
    logic        inv_all, inv_va_en, unlock_all;
    logic [31:0] inv_va;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mpt_tlb u0 (.*);

    // {va, hit, pa, ap}
    localparam logic [66:0] VEC [0:8] = '{
        {32'h0001_2ABC, 1'b1, 32'h8000_5ABC, 2'd1},  // R2
        {32'h0001_3000, 1'b0, 32'h0,         2'd0},  // R2 miss
        {32'h0004_8123, 1'b1, 32'h9003_8123, 2'd2},  // R3 quarter 2
        {32'h0004_C000, 1'b1, 32'h9003_C000, 2'd3},  // R3 quarter 3
        {32'h0004_0010, 1'b1, 32'h9003_0010, 2'd0},  // R3 quarter 0
        {32'h0005_0000, 1'b0, 32'h0,         2'd0},  // R3 miss
        {32'h012F_FFFF, 1'b1, 32'hA05F_FFFF, 2'd3},  // R4
        {32'h0130_0000, 1'b0, 32'h0,         2'd0},  // R4 miss
        {32'h0120_5004, 1'b1, 32'hA050_5004, 2'd3}   // R5 lowest wins
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] va, input bit eh, input logic [31:0] epa,
                        input logic [1:0] eap, input string req);
        @(negedge clk);
        lk_req = 1'b1;
        lk_va  = va;
        #1;
        check(lk_hit == eh && lk_miss == !eh && lk_pa == (eh ? epa : 32'h0) && lk_ap == (eh ? eap : 2'd0),
              req, {lk_hit, lk_miss, lk_ap, 28'h0, lk_pa}, {eh, !eh, eap, 28'h0, epa});
        lk_req = 1'b0;
    endtask

    task automatic refill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                          input logic [7:0] ap, input bit lck);
        @(negedge clk);
        rf_we = 1'b1; rf_va = va; rf_pa = pa; rf_size = sz; rf_ap = ap; rf_lock = lck;
        @(negedge clk);
        rf_we = 1'b0;
    endtask

    task automatic pulse_inv_all();
        @(negedge clk); inv_all = 1'b1;
        @(negedge clk); inv_all = 1'b0;
    endtask

    task automatic pulse_unlock();
        @(negedge clk); unlock_all = 1'b1;
        @(negedge clk); unlock_all = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; lk_req = 0; lk_va = 0; rf_we = 0; rf_size = 0; rf_va = 0; rf_pa = 0;
        rf_ap = 0; rf_lock = 0; inv_all = 0; inv_va_en = 0; inv_va = 0; unlock_all = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(rf_err == 1'b0, "R1 err", 64'(rf_err), 64'd0);
        check(lk_hit == 0 && lk_miss == 0, "R5 idle outputs", {lk_hit, lk_miss}, 64'd0);
        look(32'h0000_0000, 1'b0, 0, 0, "R1 empty");

        // R6: size code 00 is not written
        refill(32'h0777_7000, 32'hC000_0000, 2'b00, 8'h1, 1'b0);
        look(32'h0777_7000, 1'b0, 0, 0, "R6 null size");

        refill(32'h0001_2000, 32'h8000_5000, 2'b01, 8'h01, 1'b0);  // entry 0 small
        refill(32'h0004_0000, 32'h9003_0000, 2'b10, 8'hE4, 1'b0);  // entry 1 large
        refill(32'h0120_0000, 32'hA050_0000, 2'b11, 8'h03, 1'b0);  // entry 2 section
        refill(32'h0120_5000, 32'hB000_0000, 2'b01, 8'h02, 1'b0);  // entry 3 small

        foreach (VEC[i]) begin
            look(VEC[i][66:35], VEC[i][34], VEC[i][33:2], VEC[i][1:0], $sformatf("R2-4 vec%0d", i));
        end

        // R10: selective invalidate drops only the large page
        @(negedge clk); inv_va_en = 1'b1; inv_va = 32'h0004_1234;
        @(negedge clk); inv_va_en = 1'b0;
        look(32'h0004_8123, 1'b0, 0, 0, "R10 large gone");
        look(32'h0001_2ABC, 1'b1, 32'h8000_5ABC, 2'd1, "R10 small kept");

        // R12: invalidate beats refill; lookup sees old contents
        @(negedge clk);
        inv_va_en = 1'b1; inv_va = 32'h0001_2000;
        rf_we = 1'b1; rf_va = 32'h0300_0000; rf_pa = 32'h1; rf_size = 2'b01; rf_ap = 0; rf_lock = 0;
        lk_req = 1'b1; lk_va = 32'h0001_2004;
        #1;
        check(lk_hit == 1'b1 && lk_pa == 32'h8000_5004, "R12 pre-update lookup", {lk_hit, lk_pa}, {1'b1, 32'h8000_5004});
        @(negedge clk);
        inv_va_en = 1'b0; rf_we = 1'b0; lk_req = 1'b0;
        look(32'h0001_2004, 1'b0, 0, 0, "R12 invalidated");
        look(32'h0300_0000, 1'b0, 0, 0, "R12 refill dropped");

        // R7, R9: round robin skips a locked entry
        do_reset();
        refill(32'h0000_0000, 32'h0000_0000, 2'b01, 8'h0, 1'b1);
        for (int k = 1; k < 64; k++) refill(32'(k) << 12, 32'(k) << 12, 2'b01, 8'h0, 1'b0);
        refill(32'h0200_0000, 32'hD000_0000, 2'b01, 8'h1, 1'b0);
        look(32'h0000_1000, 1'b0, 0, 0, "R7 entry1 evicted");
        look(32'h0000_0010, 1'b1, 32'h0000_0010, 2'd0, "R7 locked kept");
        look(32'h0200_0008, 1'b1, 32'hD000_0008, 2'd1, "R7 new entry");
        look(32'h0000_2000, 1'b1, 32'h0000_2000, 2'd0, "R7 entry2 kept");
        pulse_inv_all();
        look(32'h0000_0010, 1'b1, 32'h0000_0010, 2'd0, "R9 locked survives");
        look(32'h0000_2000, 1'b0, 0, 0, "R9 unlocked gone");
        look(32'h0200_0008, 1'b0, 0, 0, "R9 new gone");

        // R8, R11: all locked
        do_reset();
        for (int k = 0; k < 64; k++) refill(32'(k) << 12, 32'(k) << 12, 2'b01, 8'h0, 1'b1);
        check(rf_err == 1'b0, "R8 no err while room", 64'(rf_err), 64'd0);
        refill(32'h0100_0000, 32'hE000_0000, 2'b01, 8'h0, 1'b0);
        check(rf_err == 1'b1, "R8 err raised", 64'(rf_err), 64'd1);
        @(negedge clk);
        check(rf_err == 1'b0, "R8 err one cycle", 64'(rf_err), 64'd0);
        look(32'h0100_0000, 1'b0, 0, 0, "R8 refill dropped");
        look(32'h0003_F000, 1'b1, 32'h0003_F000, 2'd0, "R8 last kept");
        pulse_unlock();
        pulse_inv_all();
        look(32'h0000_5000, 1'b0, 0, 0, "R11 unlocked then flushed");
        refill(32'h0100_0000, 32'hE000_0000, 2'b01, 8'h0, 1'b0);
        check(rf_err == 1'b0, "R11 refill accepted", 64'(rf_err), 64'd0);
        look(32'h0100_0ABC, 1'b1, 32'hE000_0ABC, 2'd0, "R11 new hit");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule